// File: doc/BRIEF.md
# Two-Bank Interrupt Aggregator

This block gathers a set of peripheral interrupt lines, split evenly into a low bank and a high bank, and folds them into one interrupt request for the processor. Each bank keeps one pending bit per line and one enable bit per line. Software reaches the block through a small synchronous register port. The port has a byte offset, a write strobe, a read strobe, write data and registered read data.

A pending bit tracks its source line. It sets when the line rises and drops when the line falls. Software may also knock a pending bit down by writing a one to the bank's clear register. If the line is still high, the bit comes back one cycle later. The view register of each bank returns pending AND enable, not the raw pending bits. The processor request is the registered OR of both masked banks.

The register window is 256 bytes wide. The high bank sits at 0x10 to 0x1c and the low bank at 0x20 to 0x2c. Within each bank, base+0x0 is the masked view, base+0x4 is the enable mask, base+0x8 is the clear port and base+0xc is reserved. Any other offset, including a misaligned one, is flagged on a one-cycle error output.

Top module: `irq_dual_bank_ctrl`

## Requirements
- R1: After reset, every pending bit, every enable bit, `irq`, `rdata` and `bad_addr` are zero.
- R2: A rising source line sets its pending bit at the next clock edge. Bit i of a bank's registers belongs to line i of that bank: `src_lo` feeds the low bank and `src_hi` feeds the high bank.
- R3: A falling source line clears its pending bit at the next clock edge. A pending bit is never one unless its source was high at the previous edge.
- R4: Offset 0x14 holds the high-bank enable mask and 0x24 holds the low-bank enable mask. Both are written whole and read back unchanged.
- R5: Writing to 0x18 (high bank) or 0x28 (low bank) clears each pending bit whose write-data bit is one, and bits written as zero are untouched. If the source is still high, the bit is one again one cycle after the clear took effect.
- R6: When a source rises in the same cycle as a clear of its bit, the bit ends up set.
- R7: A read of 0x10 returns high pending AND high enable, and a read of 0x20 returns the same for the low bank. Writes to these two offsets change nothing.
- R8: `irq` is one exactly when some bit of (pending AND enable) in either bank was one at the previous clock edge. This gives one cycle of latency after a pending or enable register changes.
- R9: Offsets 0x1c and 0x2c read as zero, ignore writes and raise no error.
- R10: Any other offset, or an offset that is not a multiple of four, reads as zero and ignores writes. Such an access makes `bad_addr` high for exactly the cycle after it.
- R11: `rdata` is updated in the cycle after `rd_en` and holds its value while no read is strobed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_lo | input | 32 | Low-bank interrupt source lines |
| src_hi | input | 32 | High-bank interrupt source lines |
| addr | input | 8 | Byte offset within the register window |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| bad_addr | output | 1 | One-cycle flag for an access to an unmapped offset |
| irq | output | 1 | Registered interrupt request to the processor |

## Verification
A source rise and a software clear of the same pending bit can land on one clock edge, and the design must let the set win. The bench raises a low-bank line on the very edge that writes a one to that bit of the clear port. It then reads the masked view on the next edge, when a lost set would still read as zero before the held-high re-arm could mask the loss. A second collision pits a clear against a line that is already held high: the view must read zero for one cycle and return to one on the cycle after.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

  localparam int unsigned BANKS    = 2;
  localparam int unsigned BANK_LO  = 0;
  localparam int unsigned BANK_HI  = 1;

  // word offsets within a bank
  localparam logic [3:0] FLD_VIEW  = 4'h0;
  localparam logic [3:0] FLD_MASK  = 4'h4;
  localparam logic [3:0] FLD_CLEAR = 4'h8;
  localparam logic [3:0] FLD_RSVD  = 4'hc;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_VIEW,
    SEL_MASK,
    SEL_CLEAR,
    SEL_RSVD
  } field_e;

  // byte base of each bank inside the window
  function automatic logic [7:0] bank_base(input int unsigned b);
    return (b == BANK_HI) ? 8'h10 : 8'h20;
  endfunction

endpackage

// File: rtl/irqagg_bank.sv
module irqagg_bank #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src,
  input  logic         mask_we,
  input  logic [N-1:0] mask_wdata,
  input  logic [N-1:0] clr_bits,
  output logic [N-1:0] status,
  output logic [N-1:0] mask,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall,
  output logic [N-1:0] masked
);

  logic [N-1:0] src_q;
  logic [N-1:0] status_nx;

  function automatic logic [N-1:0] edge_up(input logic [N-1:0] now, input logic [N-1:0] prev);
    return now & ~prev;
  endfunction

  function automatic logic [N-1:0] edge_down(input logic [N-1:0] now, input logic [N-1:0] prev);
    return ~now & prev;
  endfunction

  // a set (edge or held-high re-arm) takes priority over any clear
  function automatic logic [N-1:0] step_status(
    input logic [N-1:0] st,
    input logic [N-1:0] now,
    input logic [N-1:0] prev,
    input logic [N-1:0] clr
  );
    logic [N-1:0] rearm;
    rearm = now & prev & ~st;
    return edge_up(now, prev) | rearm | (st & ~(clr | edge_down(now, prev)));
  endfunction

  assign rise      = edge_up(src, src_q);
  assign fall      = edge_down(src, src_q);
  assign status_nx = step_status(status, src, src_q, clr_bits);
  assign masked    = status & mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      status <= '0;
      mask   <= '0;
    end else begin
      src_q  <= src;
      status <= status_nx;
      if (mask_we) mask <= mask_wdata;
    end
  end

endmodule

// File: rtl/irqagg_decode.sv
module irqagg_decode
  import irqagg_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  output logic [BANKS-1:0]  view_sel,
  output logic [BANKS-1:0]  mask_sel,
  output logic [BANKS-1:0]  clr_sel,
  output logic              rsvd_sel,
  output logic              bad
);

  localparam int unsigned TOP_W = ADDR_W - 4;

  field_e              fld [BANKS];
  logic [BANKS-1:0]    rsvd_b;
  logic                any_hit;

  function automatic field_e classify(input logic [ADDR_W-1:0] a, input logic [7:0] base);
    logic [ADDR_W-1:0] b;
    b = ADDR_W'(base);
    if (a[ADDR_W-1:4] != b[ADDR_W-1:4]) return SEL_NONE;
    case (a[3:0])
      FLD_VIEW:  return SEL_VIEW;
      FLD_MASK:  return SEL_MASK;
      FLD_CLEAR: return SEL_CLEAR;
      FLD_RSVD:  return SEL_RSVD;
      default:   return SEL_NONE;
    endcase
  endfunction

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    assign fld[b]      = classify(addr, bank_base(b));
    assign view_sel[b] = (fld[b] == SEL_VIEW);
    assign mask_sel[b] = (fld[b] == SEL_MASK);
    assign clr_sel[b]  = (fld[b] == SEL_CLEAR);
    assign rsvd_b[b]   = (fld[b] == SEL_RSVD);
  end

  assign rsvd_sel = |rsvd_b;
  assign any_hit  = |{view_sel, mask_sel, clr_sel, rsvd_b};
  assign bad      = (rd_en | wr_en) & ~any_hit;

  logic unused_top;
  assign unused_top = ^TOP_W;

endmodule

// File: rtl/irqagg_output.sv
module irqagg_output
  import irqagg_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd_en,
  input  logic                     bad,
  input  logic [BANKS-1:0]         view_sel,
  input  logic [BANKS-1:0]         mask_sel,
  input  logic [BANKS-1:0][N-1:0]  masked,
  input  logic [BANKS-1:0][N-1:0]  mask,
  output logic                     masked_any,
  output logic [N-1:0]             rdata,
  output logic                     bad_addr,
  output logic                     irq
);

  logic [BANKS-1:0][N-1:0] pick;
  logic [N-1:0]            rd_value;

  function automatic logic [N-1:0] or_reduce_banks(input logic [BANKS-1:0][N-1:0] v);
    logic [N-1:0] acc;
    acc = '0;
    for (int b = 0; b < BANKS; b++) acc |= v[b];
    return acc;
  endfunction

  for (genvar b = 0; b < BANKS; b++) begin : g_pick
    assign pick[b] = ({N{view_sel[b]}} & masked[b]) | ({N{mask_sel[b]}} & mask[b]);
  end

  assign rd_value   = or_reduce_banks(pick);
  assign masked_any = |or_reduce_banks(masked);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata    <= '0;
      bad_addr <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (rd_en) rdata <= rd_value;
      bad_addr <= bad;
      irq      <= masked_any;
    end
  end

endmodule

// File: rtl/irq_dual_bank_ctrl.sv
module irq_dual_bank_ctrl
  import irqagg_pkg::*;
#(
  parameter int unsigned LINES  = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  src_lo,
  input  logic [LINES-1:0]  src_hi,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [LINES-1:0]  wdata,
  output logic [LINES-1:0]  rdata,
  output logic              bad_addr,
  output logic              irq
);

  logic [BANKS-1:0]             view_sel, mask_sel, clr_sel;
  logic                         rsvd_sel;
  logic                         bad;
  logic [BANKS-1:0][LINES-1:0]  src_all, st_all, mask_all, rise_all, fall_all, masked_all;
  logic                         masked_any;

  // named views for the checker
  logic [LINES-1:0] status_lo, status_hi, mask_lo, mask_hi, rise_lo, rise_hi;

  assign src_all[BANK_LO] = src_lo;
  assign src_all[BANK_HI] = src_hi;

  irqagg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr     (addr),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .view_sel (view_sel),
    .mask_sel (mask_sel),
    .clr_sel  (clr_sel),
    .rsvd_sel (rsvd_sel),
    .bad      (bad)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [LINES-1:0] clr_bits;
    assign clr_bits = (wr_en && clr_sel[b]) ? wdata : '0;

    irqagg_bank #(.N(LINES)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .src        (src_all[b]),
      .mask_we    (wr_en && mask_sel[b]),
      .mask_wdata (wdata),
      .clr_bits   (clr_bits),
      .status     (st_all[b]),
      .mask       (mask_all[b]),
      .rise       (rise_all[b]),
      .fall       (fall_all[b]),
      .masked     (masked_all[b])
    );
  end

  irqagg_output #(.N(LINES)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .bad        (bad),
    .view_sel   (view_sel),
    .mask_sel   (mask_sel),
    .masked     (masked_all),
    .mask       (mask_all),
    .masked_any (masked_any),
    .rdata      (rdata),
    .bad_addr   (bad_addr),
    .irq        (irq)
  );

  assign status_lo = st_all[BANK_LO];
  assign status_hi = st_all[BANK_HI];
  assign mask_lo   = mask_all[BANK_LO];
  assign mask_hi   = mask_all[BANK_HI];
  assign rise_lo   = rise_all[BANK_LO];
  assign rise_hi   = rise_all[BANK_HI];

  logic unused_ok;
  assign unused_ok = rsvd_sel ^ (|fall_all);

endmodule

// File: rtl/irqagg_chk.sv
module irqagg_chk #(
  parameter int unsigned N      = 32,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [N-1:0]      wdata,
  input logic [N-1:0]      src_lo,
  input logic [N-1:0]      src_hi,
  input logic [N-1:0]      status_lo,
  input logic [N-1:0]      status_hi,
  input logic [N-1:0]      mask_lo,
  input logic [N-1:0]      mask_hi,
  input logic [N-1:0]      rise_lo,
  input logic [N-1:0]      rise_hi,
  input logic              bad_addr,
  input logic              irq
);

  localparam logic [ADDR_W-1:0] A_MASK_LO = ADDR_W'(8'h24);
  localparam logic [ADDR_W-1:0] A_MASK_HI = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] A_CLR_LO  = ADDR_W'(8'h28);

  assert_rise_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_lo & $past(rise_lo)) == $past(rise_lo)) &&
             ((status_hi & $past(rise_hi)) == $past(rise_hi)));

  assert_no_set_without_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_lo & ~$past(src_lo)) == '0) && ((status_hi & ~$past(src_hi)) == '0));

  assert_mask_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_MASK_LO) |=> (mask_lo == $past(wdata)));

  assert_mask_write_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_MASK_HI) |=> (mask_hi == $past(wdata)));

  assert_clear_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CLR_LO) |=> ((status_lo & $past(wdata & status_lo & ~rise_lo)) == '0));

  assert_irq_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|((status_lo & mask_lo) | (status_hi & mask_hi)))));

  assert_bad_needs_access_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bad_addr |-> $past(rd_en || wr_en));

endmodule

bind irq_dual_bank_ctrl irqagg_chk #(.N(LINES), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .addr      (addr),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .wdata     (wdata),
  .src_lo    (src_lo),
  .src_hi    (src_hi),
  .status_lo (status_lo),
  .status_hi (status_hi),
  .mask_lo   (mask_lo),
  .mask_hi   (mask_hi),
  .rise_lo   (rise_lo),
  .rise_hi   (rise_hi),
  .bad_addr  (bad_addr),
  .irq       (irq)
);

// File: tb/test_irq_dual_bank_ctrl.sv
`timescale 1ns/1ps
module test_irq_dual_bank_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_lo = '0, src_hi = '0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        bad_addr, irq;

  int checks = 0;
  int failures = 0;
  logic [31:0] got;

  always #2.5 clk = ~clk;

  irq_dual_bank_ctrl i_irq_dual_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .src_lo(src_lo), .src_hi(src_hi),
    .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
    .rdata(rdata), .bad_addr(bad_addr), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  function automatic bit mapped(input logic [7:0] a);
    return a inside {8'h10, 8'h14, 8'h18, 8'h1c, 8'h20, 8'h24, 8'h28, 8'h2c};
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [31:0] en_lo_m, en_hi_m, held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(irq == 1'b0, "R1 irq", {31'b0, irq}, 0);
    check(bad_addr == 1'b0, "R1 bad_addr", {31'b0, bad_addr}, 0);
    check(rdata == '0, "R1 rdata", rdata, 0);
    rd(8'h24, got); check(got == '0, "R1 mask_lo", got, 0);
    rd(8'h14, got); check(got == '0, "R1 mask_hi", got, 0);

    // R4 enable registers
    wr(8'h24, 32'ha5a5_3c3c); rd(8'h24, got); check(got == 32'ha5a5_3c3c, "R4 lo", got, 32'ha5a5_3c3c);
    wr(8'h14, 32'h0ff0_1234); rd(8'h14, got); check(got == 32'h0ff0_1234, "R4 hi", got, 32'h0ff0_1234);
    rd(8'h24, got); check(got == 32'ha5a5_3c3c, "R4 lo kept", got, 32'ha5a5_3c3c);

    // R2 R3 R7 R8 line sweep on both banks, everything enabled
    wr(8'h24, '1); wr(8'h14, '1);
    for (int b = 0; b < 2; b++) begin
      for (int i = 0; i < 32; i++) begin
        if (b == 0) src_lo = 32'h1 << i; else src_hi = 32'h1 << i;
        @(negedge clk);
        rd(b == 0 ? 8'h20 : 8'h10, got);
        check(got == (32'h1 << i), "R2 set line", got, 32'h1 << i);
        check(irq == 1'b1, "R8 irq on", {31'b0, irq}, 1);
        src_lo = '0; src_hi = '0;
        @(negedge clk);
        rd(b == 0 ? 8'h20 : 8'h10, got);
        check(got == '0, "R3 cleared on fall", got, 0);
        check(irq == 1'b0, "R8 irq off", {31'b0, irq}, 0);
      end
    end

    // R7 masking, R8 latency after enable write
    wr(8'h24, '0); wr(8'h14, '0);
    src_lo = 32'h0000_0008;
    @(negedge clk); @(negedge clk);
    rd(8'h20, got); check(got == '0, "R7 masked view", got, 0);
    check(irq == 1'b0, "R8 masked no irq", {31'b0, irq}, 0);
    wr(8'h24, 32'h0000_0008);
    check(irq == 1'b0, "R8 one-cycle latency", {31'b0, irq}, 0);
    @(negedge clk);
    check(irq == 1'b1, "R8 irq after enable", {31'b0, irq}, 1);
    rd(8'h20, got); check(got == 32'h8, "R7 view lo", got, 32'h8);

    // R7 write to view ignored
    wr(8'h20, '0); wr(8'h10, '1);
    rd(8'h20, got); check(got == 32'h8, "R7 view write ignored", got, 32'h8);
    rd(8'h24, got); check(got == 32'h8, "R7 mask untouched", got, 32'h8);
    rd(8'h10, got); check(got == '0, "R7 hi view write ignored", got, 0);

    // R5 clear zeros does nothing, clear of held-high line re-arms
    wr(8'h28, 32'hffff_fff7);
    rd(8'h20, got); check(got == 32'h8, "R5 zero bit kept", got, 32'h8);
    wr(8'h28, 32'h0000_0008);
    rd(8'h20, got); check(got == '0, "R5 cleared", got, 0);
    rd(8'h20, got); check(got == 32'h8, "R5 re-armed", got, 32'h8);

    // R5 high bank clear
    wr(8'h14, 32'h0001_0000); src_hi = 32'h0001_0000;
    @(negedge clk);
    wr(8'h18, 32'h0001_0000);
    rd(8'h10, got); check(got == '0, "R5 hi cleared", got, 0);
    rd(8'h10, got); check(got == 32'h0001_0000, "R5 hi re-armed", got, 32'h0001_0000);
    src_hi = '0;

    // R6 rise and clear in the same cycle: set wins
    wr(8'h24, 32'h0000_0020); src_lo = '0;
    @(negedge clk);
    src_lo = 32'h0000_0020;
    wr(8'h28, 32'h0000_0020);
    rd(8'h20, got); check(got == 32'h20, "R6 set wins", got, 32'h20);
    src_lo = '0;
    @(negedge clk);

    // R9 reserved offsets
    wr(8'h24, 32'h1234_5678); wr(8'h14, 32'h9abc_def0);
    en_lo_m = 32'h1234_5678; en_hi_m = 32'h9abc_def0;
    wr(8'h2c, '1);
    check(bad_addr == 1'b0, "R9 no error 2c", {31'b0, bad_addr}, 0);
    wr(8'h1c, '1);
    check(bad_addr == 1'b0, "R9 no error 1c", {31'b0, bad_addr}, 0);
    rd(8'h2c, got); check(got == '0, "R9 read 2c", got, 0);
    rd(8'h1c, got); check(got == '0, "R9 read 1c", got, 0);

    // R10 R11 sweep of the whole window plus misaligned offsets
    for (int o = 0; o < 256; o += 4) begin
      logic [31:0] exp;
      bit eb;
      exp = (o == 8'h14) ? en_hi_m : (o == 8'h24) ? en_lo_m : 32'h0;
      eb = !mapped(8'(o));
      rd(8'(o), got);
      check(got == exp, "R10 read value", got, exp);
      check(bad_addr == eb, "R10 error pulse", {31'b0, bad_addr}, {31'b0, eb});
      held = got;
      @(negedge clk);
      check(bad_addr == 1'b0, "R10 pulse one cycle", {31'b0, bad_addr}, 0);
      check(rdata == held, "R11 rdata holds", rdata, held);
      if (eb) wr(8'(o), 32'hdead_beef);
    end
    rd(8'h21, got); check(got == '0 && bad_addr, "R10 misaligned", got, 0);
    wr(8'h26, '0); check(bad_addr == 1'b1, "R10 misaligned write", {31'b0, bad_addr}, 1);
    rd(8'h24, got); check(got == en_lo_m, "R10 writes ignored lo", got, en_lo_m);
    rd(8'h14, got); check(got == en_hi_m, "R10 writes ignored hi", got, en_hi_m);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule